// File: doc/BRIEF.md
# Serial Dual Frequency Word Loader

This block loads frequency tuning words one bit at a time. It uses a dedicated serial clock and a single data line. The bits collect in a 64-bit shift register that can shift in either direction. The register holds two 32-bit tuning words at the same time. A word-select input routes one half of the register to a phase accumulator further down the chain. Toggling the word select switches between the two stored words, so the loader supports binary frequency-shift keying with no reload.

The shift direction also decides where a new word ends up:

- When the most significant bit is sent first, bits enter at the bottom of the register and move upward. A 32-bit load therefore ends in the low half.
- When the least significant bit is sent first, bits enter at the top and move downward. The new word ends in the high half.

For single-word use, the word select must therefore match the direction setting. Loading a second word pushes the first word into the other half, ready for keying.

The output multiplexer is combinational. The downstream logic samples it on its own system clock, and that path is assumed to meet setup.

Top module: `freq_word_loader`

## Requirements
- R1: An active-low asynchronous reset clears all 64 register bits, so the output reads zero under either word select.
- R2: While the active-low shift enable is high, rising serial clock edges leave the register and the output unchanged.
- R3: With shift enabled and the direction input high (most significant bit first), each rising serial clock edge moves the register contents up by one place and places the data bit at bit 0.
- R4: With shift enabled and the direction input low (least significant bit first), each rising serial clock edge moves the register contents down by one place and places the data bit at bit 63.
- R5: After 32 shifts with the most significant bit first, the 32-bit word that was sent appears on the output when the word select is high.
- R6: After 32 shifts with the least significant bit first, the 32-bit word that was sent appears on the output when the word select is low.
- R7: A high word select passes register bits 31:0 to the output, and a low word select passes bits 63:32. The output follows the word select without a clock edge.
- R8: A second 32-bit load in the same direction pushes the previous word, unchanged, into the other half of the register, so both words can be selected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| serClk | input | 1 | Serial clock; the register shifts on its rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| serData | input | 1 | Serial data bit |
| shiftEnN | input | 1 | Shift enable, active low |
| msbFirst | input | 1 | 1: most significant bit first (enters at bit 0); 0: least significant bit first (enters at bit 63) |
| wordSel | input | 1 | 1: output bits 31:0; 0: output bits 63:32 |
| freqWord | output | 32 | Selected tuning word |

## Verification
The assertions assume that shift enable, direction and serial data are settled before each rising serial clock edge. They also assume that the word select changes only between edges whenever the idle-output property is to apply. The stimulus meets both conditions by changing every input on the falling edge and reading the combinational output midway through the low phase.

The stimulus sweeps a set of edge and walking-bit words through both directions. It loads two words in a row so that the displaced word can be checked in the other half.

// File: rtl/freq_loader_pkg.sv
package freq_loader_pkg;
  typedef struct packed {
    logic stepUp;
    logic stepDown;
  } shiftStrobe_t;
endpackage

// File: rtl/freq_loader_ctrl.sv
module freq_loader_ctrl
  import freq_loader_pkg::*;
(
  input  logic         shiftEnN,
  input  logic         msbFirst,
  output shiftStrobe_t strobe
);
  logic shiftOn;
  assign shiftOn = ~shiftEnN;

  always_comb begin
    strobe          = '0;
    strobe.stepUp   = shiftOn & msbFirst;
    strobe.stepDown = shiftOn & ~msbFirst;
  end
endmodule

// File: rtl/freq_loader_path.sv
module freq_loader_path
  import freq_loader_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              serClk,
  input  logic              rstN,
  input  logic              serData,
  input  shiftStrobe_t      strobe,
  input  logic              wordSel,
  output logic [WORD_W-1:0] freqWord
);
  localparam int REG_W = 2 * WORD_W;

  logic [REG_W-1:0] shiftReg;
  logic             stepUp;
  logic             stepDown;

  assign stepUp   = strobe.stepUp;
  assign stepDown = strobe.stepDown;

  always_ff @(posedge serClk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
    end else if (stepUp) begin
      shiftReg <= {shiftReg[REG_W-2:0], serData};
    end else if (stepDown) begin
      shiftReg <= {serData, shiftReg[REG_W-1:1]};
    end
  end

  generate
    if (WORD_W > 0) begin : g_mux
      assign freqWord = wordSel ? shiftReg[WORD_W-1:0] : shiftReg[REG_W-1:WORD_W];
    end
  endgenerate

  logic histValid;
  always_ff @(posedge serClk or negedge rstN) begin
    if (!rstN) histValid <= 1'b0;
    else       histValid <= 1'b1;
  end

  AST_HOLD_IDLE: assert property (@(posedge serClk) disable iff (!rstN)
    (histValid && !$past(stepUp) && !$past(stepDown)) |-> $stable(shiftReg)); // R2

  AST_UP_ENTRY: assert property (@(posedge serClk) disable iff (!rstN)
    (histValid && $past(stepUp)) |->
      (shiftReg[0] == $past(serData) && shiftReg[REG_W-1] == $past(shiftReg[REG_W-2]))); // R3

  AST_DOWN_ENTRY: assert property (@(posedge serClk) disable iff (!rstN)
    (histValid && $past(stepDown)) |->
      (shiftReg[REG_W-1] == $past(serData) && shiftReg[0] == $past(shiftReg[1]))); // R4

  AST_IDLE_OUT: assert property (@(posedge serClk) disable iff (!rstN)
    (histValid && !$past(stepUp) && !$past(stepDown) && $stable(wordSel)) |-> $stable(freqWord)); // R7
endmodule

// File: rtl/freq_word_loader.sv
module freq_word_loader
  import freq_loader_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              serClk,
  input  logic              rstN,
  input  logic              serData,
  input  logic              shiftEnN,
  input  logic              msbFirst,
  input  logic              wordSel,
  output logic [WORD_W-1:0] freqWord
);
  shiftStrobe_t strobe;

  freq_loader_ctrl u_ctrl (
    .shiftEnN (shiftEnN),
    .msbFirst (msbFirst),
    .strobe   (strobe)
  );

  freq_loader_path #(.WORD_W(WORD_W)) u_path (
    .serClk   (serClk),
    .rstN     (rstN),
    .serData  (serData),
    .strobe   (strobe),
    .wordSel  (wordSel),
    .freqWord (freqWord)
  );
endmodule

// File: tb/freq_word_loader_tb.sv
module freq_word_loader_tb;
  localparam int W = 32;

  logic         serClk = 1'b0;
  logic         rstN = 1'b0;
  logic         serData = 1'b0;
  logic         shiftEnN = 1'b1;
  logic         msbFirst = 1'b1;
  logic         wordSel = 1'b1;
  logic [W-1:0] freqWord;

  int total = 0;
  int bad = 0;

  always #2 serClk = ~serClk;

  freq_word_loader #(.WORD_W(W)) u_dut (
    .serClk(serClk), .rstN(rstN), .serData(serData), .shiftEnN(shiftEnN),
    .msbFirst(msbFirst), .wordSel(wordSel), .freqWord(freqWord)
  );

  task automatic check(input string req, input logic [W-1:0] exp);
    total++;
    if (freqWord !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, freqWord, exp);
    end
  endtask

  task automatic peek(input logic sel, input string req, input logic [W-1:0] exp);
    wordSel = sel;
    #0.5;
    check(req, exp);
  endtask

  task automatic loadWord(input logic [W-1:0] w, input logic msb);
    for (int i = 0; i < W; i++) begin
      @(negedge serClk);
      msbFirst = msb;
      serData  = msb ? w[W-1-i] : w[i];
      shiftEnN = 1'b0;
    end
    @(negedge serClk);
    shiftEnN = 1'b1;
  endtask

  function automatic logic [W-1:0] pattern(input int k);
    case (k)
      0: return '0;
      1: return '1;
      2: return 32'h8000_0001;
      3: return 32'hA5A5_5A5A;
      4: return 32'h2000_0000;
      default: return (32'h1 << (k - 5)) ^ (32'h9E37_79B9 * k);
    endcase
  endfunction

  initial begin
    #200000;
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [W-1:0] prev;
    #10;
    peek(1'b1, "R1 low half after reset", '0);
    peek(1'b0, "R1 high half after reset", '0);
    rstN = 1'b1;

    // R3 R5 R8 R7: MSB-first sweep
    prev = '0;
    for (int k = 0; k < 24; k++) begin
      loadWord(pattern(k), 1'b1);
      peek(1'b1, "R5 R3 R7 msb-first word in low half", pattern(k));
      peek(1'b0, "R8 R7 previous word pushed high", prev);
      prev = pattern(k);
    end

    // R2: idle clocks with data toggling
    for (int i = 0; i < 20; i++) begin
      @(negedge serClk);
      serData = i[0];
      msbFirst = i[1];
    end
    peek(1'b1, "R2 low half held while disabled", prev);
    peek(1'b0, "R2 high half held while disabled", pattern(22));

    // R4 R6 R8: LSB-first sweep; first load pushes top (pattern 22) down
    prev = pattern(22);
    for (int k = 0; k < 24; k++) begin
      loadWord(pattern(23 - k), 1'b0);
      peek(1'b0, "R6 R4 R7 lsb-first word in high half", pattern(23 - k));
      peek(1'b1, "R8 previous word pushed low", prev);
      prev = pattern(23 - k);
    end

    // R1: asynchronous reset mid-stream
    @(negedge serClk);
    #1 rstN = 1'b0;
    peek(1'b1, "R1 async reset low half", '0);
    peek(1'b0, "R1 async reset high half", '0);
    @(negedge serClk);
    rstN = 1'b1;

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule